// File: doc/BRIEF.md
# Counted Transfer Redirect Controller

This block sits in the load/store issue path of a small microcontroller. It decides where each transfer-class instruction (wait, data store, data load) is sent. Normally every such instruction goes to the DMA path. A one-byte redirect command arms a window that covers a programmed number of later transfer instructions. Inside that window each transfer instruction is steered to a different target, chosen by the type held in the command. The window closes by itself once its count is used up. The block only produces routing selects and flags. The data movement itself happens elsewhere.

The command byte carries a three-bit type and a five-bit count. The low two bits of the type pick the base target. The top type bit is a modifier that can be combined with any base target and is reported on its own output. When the base target is the crypto register file, a store's length field is reused as the register index.

Top module: `xfer_redirect_ctl`

## Requirements
- R1: After reset no window is armed, and every transfer instruction gets routeSel = 0 (DMA) with modFlag, lenAsReg and unknownType low.
- R2: The command byte holds the type in bits 7:5 and the count in bits 4:0. A count of N redirects exactly the next N transfer instructions. Transfer instruction N+1 goes back to routeSel = 0.
- R3: Base type 00 (command type 000) gives routeSel = 1, local data memory to or from an indexed crypto register.
- R4: Base type 01 (command type 001) gives routeSel = 2, external memory to or from the crypto stream.
- R5: Base type 11 (command type 011) gives routeSel = 3, local data memory to or from the crypto stream.
- R6: Type bit 2 (command bit 7) is a modifier. When it is set, routing still follows the base type, and modFlag is high for every redirected instruction whose target is known.
- R7: insnClass encodes 0 = other, 1 = wait, 2 = store, 3 = load. Classes 1 to 3 each use up one count. Class 0 is routed to 0, raises no flag and leaves the count unchanged.
- R8: Under base type 00, a store (class 2) sets lenAsReg = 1 and cregIdx equal to the low IDX_W bits of insnLen. A wait or a load under base type 00 leaves lenAsReg = 0.
- R9: A command with count 0 ends any armed window. The next transfer instruction gets routeSel = 0.
- R10: A new command replaces the type and the remaining count. A transfer instruction issued in the same cycle as the command is routed by the old window.
- R11: Base type 10 (command type 010 or 110) raises unknownType for each instruction in the window. That instruction is routed to 0 with modFlag low, and it still uses up one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Redirect command strobe |
| cmdByte | input | TYPE_W+CNT_W | Command: type in the upper bits, count in the lower bits |
| insnValid | input | 1 | Instruction issue strobe |
| insnClass | input | 2 | Instruction class: 0 other, 1 wait, 2 store, 3 load |
| insnLen | input | LEN_W | Length field of the instruction |
| routeSel | output | 2 | Target: 0 DMA, 1 dmem-creg, 2 ext-stream, 3 dmem-stream |
| modFlag | output | 1 | Modifier type bit applied to this instruction |
| lenAsReg | output | 1 | Length field is to be read as a crypto register index |
| cregIdx | output | IDX_W | Crypto register index taken from insnLen |
| unknownType | output | 1 | The window's base type has no defined meaning |

## Verification
The bench targets the edge of the window. A design with an off-by-one error in the count would redirect one instruction too many or too few, and the bench checks instruction N+1 after both short and full-width counts. Other corner cases are non-transfer instructions issued inside a window, a zero-count command, and a command that arrives in the same cycle as a transfer. A design that let class 0 use up a count, or that applied a new command one cycle early, would misroute the instruction that follows. The reserved base type is also exercised: a design that failed to use up a count on it, or that routed such an instruction away from DMA, shows up at once.

// File: rtl/xfer_redirect_pkg.sv
package xfer_redirect_pkg;

  typedef enum logic [1:0] {
    RT_DMA         = 2'd0,
    RT_DMEM_CREG   = 2'd1,
    RT_EXT_STREAM  = 2'd2,
    RT_DMEM_STREAM = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    CL_OTHER = 2'd0,
    CL_WAIT  = 2'd1,
    CL_STORE = 2'd2,
    CL_LOAD  = 2'd3
  } insn_class_e;

  // Base-type encodings (low two type bits)
  localparam logic [1:0] BASE_CREG   = 2'b00;
  localparam logic [1:0] BASE_EXT    = 2'b01;
  localparam logic [1:0] BASE_RSVD   = 2'b10;
  localparam logic [1:0] BASE_DSTRM  = 2'b11;

  // Window state handed from control to datapath
  typedef struct packed {
    logic       active;
    logic [1:0] base;
    logic       modifier;
  } ovr_state_t;

endpackage

// File: rtl/xfer_redirect_ctrl.sv
module xfer_redirect_ctrl
  import xfer_redirect_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int CNT_W  = 5,
  localparam int CMD_W = TYPE_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             consume,
  output ovr_state_t       ovr
);

  localparam int MOD_BIT = TYPE_W - 1;

  logic [TYPE_W-1:0] typeQ;
  logic [CNT_W-1:0]  cntQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      typeQ <= '0;
      cntQ  <= '0;
    end else if (cmdValid) begin
      typeQ <= cmdByte[CMD_W-1 -: TYPE_W];
      cntQ  <= cmdByte[CNT_W-1:0];
    end else if (consume && (cntQ != '0)) begin
      cntQ  <= cntQ - 1'b1;
    end
  end

  always_comb begin
    ovr.active   = (cntQ != '0);
    ovr.base     = typeQ[1:0];
    ovr.modifier = typeQ[MOD_BIT];
  end

endmodule

// File: rtl/xfer_redirect_path.sv
module xfer_redirect_path
  import xfer_redirect_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int IDX_W = 3
) (
  input  ovr_state_t       ovr,
  input  logic             insnValid,
  input  logic [1:0]       insnClass,
  input  logic [LEN_W-1:0] insnLen,
  output logic             consume,
  output logic [1:0]       routeSel,
  output logic             modFlag,
  output logic             lenAsReg,
  output logic [IDX_W-1:0] cregIdx,
  output logic             unknownType
);

  logic isXfer;
  logic hit;
  route_e route;

  always_comb begin
    isXfer = insnValid && (insn_class_e'(insnClass) != CL_OTHER);
    hit    = isXfer && ovr.active;
    route  = RT_DMA;
    unknownType = 1'b0;
    if (hit) begin
      unique case (ovr.base)
        BASE_CREG:  route = RT_DMEM_CREG;
        BASE_EXT:   route = RT_EXT_STREAM;
        BASE_DSTRM: route = RT_DMEM_STREAM;
        default:    unknownType = 1'b1;
      endcase
    end
    routeSel = route;
    modFlag  = hit && !unknownType && ovr.modifier;
    lenAsReg = hit && (ovr.base == BASE_CREG) &&
               (insn_class_e'(insnClass) == CL_STORE);
    cregIdx  = lenAsReg ? insnLen[IDX_W-1:0] : '0;
    consume  = isXfer;
  end

endmodule

// File: rtl/xfer_redirect_ctl.sv
module xfer_redirect_ctl
  import xfer_redirect_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = 8,
  parameter int IDX_W  = 3,
  localparam int CMD_W = TYPE_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             insnValid,
  input  logic [1:0]       insnClass,
  input  logic [LEN_W-1:0] insnLen,
  output logic [1:0]       routeSel,
  output logic             modFlag,
  output logic             lenAsReg,
  output logic [IDX_W-1:0] cregIdx,
  output logic             unknownType
);

  ovr_state_t ovr;
  logic       consume;

  xfer_redirect_ctrl #(.TYPE_W(TYPE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdByte  (cmdByte),
    .consume  (consume),
    .ovr      (ovr)
  );

  xfer_redirect_path #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_path (
    .ovr         (ovr),
    .insnValid   (insnValid),
    .insnClass   (insnClass),
    .insnLen     (insnLen),
    .consume     (consume),
    .routeSel    (routeSel),
    .modFlag     (modFlag),
    .lenAsReg    (lenAsReg),
    .cregIdx     (cregIdx),
    .unknownType (unknownType)
  );

endmodule

// File: rtl/xfer_redirect_chk.sv
module xfer_redirect_chk #(
  parameter int TYPE_W = 3,
  parameter int CNT_W  = 5,
  localparam int CMD_W = TYPE_W + CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmdValid,
  input logic [CMD_W-1:0] cmdByte,
  input logic             insnValid,
  input logic [1:0]       insnClass,
  input logic [1:0]       routeSel,
  input logic             modFlag,
  input logic             lenAsReg,
  input logic             unknownType
);

  // R7
  other_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!insnValid || insnClass == 2'd0) |-> (routeSel == 2'd0 && !lenAsReg && !unknownType && !modFlag));

  // R11
  unknown_to_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unknownType |-> (routeSel == 2'd0 && !modFlag && !lenAsReg));

  // R8
  len_reuse_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lenAsReg |-> (insnClass == 2'd2 && routeSel == 2'd1));

  // R9
  zero_count_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdByte[CNT_W-1:0] == '0) |=>
      (cmdValid || !(insnValid && insnClass != 2'd0) || (routeSel == 2'd0 && !unknownType)));

  // R6
  modifier_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modFlag |-> (routeSel != 2'd0));

endmodule

bind xfer_redirect_ctl xfer_redirect_chk #(.TYPE_W(TYPE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/xfer_redirect_ctl_tb.sv
module xfer_redirect_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmdValid;
  logic [7:0] cmdByte;
  logic       insnValid;
  logic [1:0] insnClass;
  logic [7:0] insnLen;
  logic [1:0] routeSel;
  logic       modFlag;
  logic       lenAsReg;
  logic [2:0] cregIdx;
  logic       unknownType;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model state
  int mType  = 0;
  int mCount = 0;

  always #4 clk = ~clk;

  xfer_redirect_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .insnValid(insnValid), .insnClass(insnClass), .insnLen(insnLen),
    .routeSel(routeSel), .modFlag(modFlag), .lenAsReg(lenAsReg),
    .cregIdx(cregIdx), .unknownType(unknownType)
  );

  task automatic step(input bit cv, input int cb, input bit iv, input int cl,
                      input int ln, input string tag);
    int eRoute, eMod, eLen, eIdx, eUnk, base;
    bit xfer;
    @(negedge clk);
    cmdValid  = cv;
    cmdByte   = cb[7:0];
    insnValid = iv;
    insnClass = cl[1:0];
    insnLen   = ln[7:0];
    #2;
    eRoute = 0; eMod = 0; eLen = 0; eIdx = 0; eUnk = 0;
    xfer = iv && (cl != 0);
    if (xfer && mCount > 0) begin
      base = mType % 4;
      if (base == 2) eUnk = 1;
      else begin
        eRoute = (base == 0) ? 1 : (base == 1) ? 2 : 3;
        eMod   = (mType / 4) % 2;
      end
      if (base == 0 && cl == 2) begin
        eLen = 1;
        eIdx = ln % 8;
      end
    end
    nChecks++;
    if (routeSel != eRoute[1:0] || modFlag != eMod[0] || lenAsReg != eLen[0] ||
        cregIdx != eIdx[2:0] || unknownType != eUnk[0]) begin
      nFails++;
      $display("FAIL %s: got route=%0d mod=%0d len=%0d idx=%0d unk=%0d exp route=%0d mod=%0d len=%0d idx=%0d unk=%0d",
               tag, routeSel, modFlag, lenAsReg, cregIdx, unknownType,
               eRoute, eMod, eLen, eIdx, eUnk);
    end
    @(posedge clk);
    if (cv) begin
      mType  = (cb / 32) % 8;
      mCount = cb % 32;
    end else if (xfer && mCount > 0) begin
      mCount--;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmdValid = 0; cmdByte = 0; insnValid = 0; insnClass = 0; insnLen = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    step(0, 0, 1, 2, 5, "R1 store after reset");
    step(0, 0, 1, 3, 0, "R1 load after reset");
    // R3 / R8 / R2
    step(1, 8'h02, 0, 0, 0, "R2 arm type000 n2");
    step(0, 0, 1, 2, 8'h0D, "R3 R8 store to creg idx");
    step(0, 0, 1, 1, 8'h07, "R8 wait no len reuse");
    step(0, 0, 1, 3, 0, "R2 expiry after two");
    // R4 / R7
    step(1, 8'h21, 0, 0, 0, "R4 arm type001 n1");
    step(0, 0, 1, 0, 0, "R7 other class passes");
    step(0, 0, 0, 2, 0, "R7 idle cycle");
    step(0, 0, 1, 3, 0, "R4 load to ext stream");
    step(0, 0, 1, 3, 0, "R2 expiry after one");
    // R5
    step(1, 8'h61, 0, 0, 0, "R5 arm type011");
    step(0, 0, 1, 2, 3, "R5 store to dmem stream");
    // R6 modifier combos
    step(1, 8'hA2, 0, 0, 0, "R6 arm 0xA2");
    step(0, 0, 1, 2, 0, "R6 mod ext stream 1");
    step(0, 0, 1, 3, 0, "R6 mod ext stream 2");
    step(0, 0, 1, 1, 0, "R6 expiry");
    step(1, 8'h81, 0, 0, 0, "R6 arm type100");
    step(0, 0, 1, 2, 8'h06, "R6 R8 mod creg store");
    step(1, 8'hE1, 0, 0, 0, "R6 arm type111");
    step(0, 0, 1, 1, 0, "R6 mod dmem stream");
    // R11 reserved base
    step(1, 8'h42, 0, 0, 0, "R11 arm type010");
    step(0, 0, 1, 2, 1, "R11 unknown flag");
    step(0, 0, 1, 0, 0, "R11 R7 other in window");
    step(0, 0, 1, 3, 0, "R11 second unknown");
    step(0, 0, 1, 3, 0, "R11 consumed count");
    step(1, 8'hC1, 0, 0, 0, "R11 arm type110");
    step(0, 0, 1, 1, 0, "R11 unknown with mod");
    // R9 zero count cancels
    step(1, 8'h05, 0, 0, 0, "R9 arm n5");
    step(0, 0, 1, 2, 2, "R9 inside window");
    step(1, 8'h20, 0, 0, 0, "R9 zero count cmd");
    step(0, 0, 1, 2, 2, "R9 cancelled");
    // R10 replace and same-cycle priority
    step(1, 8'h1F, 0, 0, 0, "R10 arm n31");
    step(1, 8'h61, 1, 2, 4, "R10 same cycle uses old");
    step(0, 0, 1, 2, 4, "R10 replaced type");
    step(0, 0, 1, 2, 4, "R10 replaced count expired");
    // R2 full-width count
    step(1, 8'h3F, 0, 0, 0, "R2 arm n31");
    for (int i = 0; i < 32; i++) step(0, 0, 1, (i % 3) + 1, i, "R2 full count window");
    step(0, 0, 1, 1, 0, "R2 after full window");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule